// File: doc/BRIEF.md
# Five-State Scrambled-Order Synchronous Counter

This block is a three-bit state counter whose flip-flops all load on the same rising clock edge, so every output bit settles together with no ripple between stages. Instead of a binary count it repeats a fixed five-value loop: 4, 7, 3, 0, 2, and then 4 again. It is meant for places that need a short repeating code pattern with a known order, such as stepping a small sequencer or producing a test pattern.

Each bit is held in a JK-style storage cell. The J and K inputs of the cells come from a small excitation network driven by the present state. A parameter can select an equivalent form built from plain next-state equations instead. The three codes that are not in the loop (1, 5 and 6) each have a fixed successor inside the loop, so the counter is back in the loop one edge after it lands on any of them. A second parameter picks the code loaded at reset. Its default is 4, the head of the loop.

Top module: `jkseq_counter`

## Requirements
- R1: While `rst_n` is low the state equals the parameter RESET_CODE (default 4, binary 100). After `rst_n` rises, the first rising clock edge moves the state to the successor of RESET_CODE.
- R2: Each rising clock edge with `rst_n` high moves a state in the loop to its successor: 4 to 7, 7 to 3, 3 to 0, 0 to 2, and 2 to 4. `state[2]` is the most significant bit of the binary code.
- R3: From any state in the loop, five consecutive edges bring the state back to the same value.
- R4: Once the state is one of 4, 7, 3, 0 or 2, every later edge keeps it inside that set.
- R5: Unused code 1 (001) moves to 2 (010) on the next edge.
- R6: Unused code 5 (101) moves to 7 (111) on the next edge.
- R7: Unused code 6 (110) moves to 3 (011) on the next edge.
- R8: With USE_JK_FORM = 1 (JK cells) or USE_JK_FORM = 0 (direct equations), the counter produces the same state sequence from the same reset code.
- R9: Pulling `rst_n` low between clock edges forces the state to RESET_CODE at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state bit updates on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; loads RESET_CODE |
| state | output | 3 | Present code; bit 2 is the MSB |

## Verification
The bench builds eight copies of the counter. One copy uses the default settings, with JK cells and reset code 4, and runs the main loop. A second copy uses the direct-equation form, so the two implementations can be compared edge by edge. The other six copies cover both forms with RESET_CODE set to 1, 5 and 6. These codes are otherwise unreachable from the ports, so these copies are the only way to reach each unused code and watch it return to the loop. All copies share one reset, which also lets the bench check a reset asserted between clock edges against every reset code at once.

// File: rtl/jkseq_pkg.sv
`timescale 1ns/1ps
package jkseq_pkg;
   localparam int STATE_W = 3;
   typedef logic [STATE_W-1:0] code_t;

   localparam int BIT_HI  = 2;
   localparam int BIT_MID = 1;
   localparam int BIT_LO  = 0;

   function automatic logic in_loop(input code_t c);
      return (c == 3'd4) || (c == 3'd7) || (c == 3'd3) ||
             (c == 3'd0) || (c == 3'd2);
   endfunction

   function automatic code_t spec_next(input code_t c);
      case (c)
         3'd4:    return 3'd7;
         3'd7:    return 3'd3;
         3'd3:    return 3'd0;
         3'd0:    return 3'd2;
         3'd2:    return 3'd4;
         3'd1:    return 3'd2;
         3'd5:    return 3'd7;
         default: return 3'd3;
      endcase
   endfunction
endpackage

// File: rtl/jkseq_excite.sv
`timescale 1ns/1ps
module jkseq_excite
   import jkseq_pkg::*;
(
   input  code_t cur,
   output code_t j_vec,
   output code_t k_vec
);
   logic hi, mid, lo;

   always_comb begin
      hi  = cur[BIT_HI];
      mid = cur[BIT_MID];
      lo  = cur[BIT_LO];
      j_vec[BIT_HI]  = mid & ~lo;
      k_vec[BIT_HI]  = mid;
      j_vec[BIT_MID] = 1'b1;
      k_vec[BIT_MID] = ~hi;
      j_vec[BIT_LO]  = hi;
      k_vec[BIT_LO]  = ~hi;
   end
endmodule

// File: rtl/jkseq_cell.sv
`timescale 1ns/1ps
module jkseq_cell #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic j,
   input  logic k,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= (j & ~q) | (~k & q);
   end
endmodule

// File: rtl/jkseq_eqnext.sv
`timescale 1ns/1ps
module jkseq_eqnext
   import jkseq_pkg::*;
(
   input  code_t cur,
   output code_t nxt
);
   always_comb begin
      nxt[BIT_HI]  = (~cur[BIT_HI] & cur[BIT_MID] & ~cur[BIT_LO]) |
                     (cur[BIT_HI] & ~cur[BIT_MID]);
      nxt[BIT_MID] = ~cur[BIT_MID] | cur[BIT_HI];
      nxt[BIT_LO]  = cur[BIT_HI];
   end
endmodule

// File: rtl/jkseq_counter.sv
`timescale 1ns/1ps
module jkseq_counter
   import jkseq_pkg::*;
#(
   parameter int    USE_JK_FORM = 1,
   parameter code_t RESET_CODE  = 3'd4
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [STATE_W-1:0] state
);
   if (USE_JK_FORM != 0 && USE_JK_FORM != 1) begin : g_bad_form
      $error("USE_JK_FORM must be 0 or 1");
   end

   code_t cur;
   assign state = cur;

   if (USE_JK_FORM == 1) begin : g_jk
      code_t j_vec, k_vec;
      jkseq_excite u_exc (.cur(cur), .j_vec(j_vec), .k_vec(k_vec));
      for (genvar b = 0; b < STATE_W; b++) begin : g_bit
         jkseq_cell #(.RST_VAL(RESET_CODE[b])) u_cell (
            .clk(clk), .rst_n(rst_n),
            .j(j_vec[b]), .k(k_vec[b]), .q(cur[b]));
      end
   end else begin : g_eq
      code_t nxt;
      jkseq_eqnext u_eq (.cur(cur), .nxt(nxt));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cur <= RESET_CODE;
         else        cur <= nxt;
      end
   end
endmodule

// File: rtl/jkseq_counter_chk.sv
`timescale 1ns/1ps
module jkseq_counter_chk
   import jkseq_pkg::*;
#(
   parameter code_t RESET_CODE = 3'd4
) (
   input logic  clk,
   input logic  rst_n,
   input code_t state
);
   logic low_prev;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) low_prev <= 1'b1;
      else        low_prev <= 1'b0;
   end

   always @(posedge clk) begin
      if (!rst_n && low_prev)
         p_reset_load_r1: assert (state == RESET_CODE)
            else $error("reset code not held");
   end

   p_loop_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_loop(state) |=> state == spec_next($past(state)));

   p_loop_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_loop(state) |=> in_loop(state));

   p_exit_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
      state == 3'd1 |=> state == 3'd2);

   p_exit_five_r6: assert property (@(posedge clk) disable iff (!rst_n)
      state == 3'd5 |=> state == 3'd7);

   p_exit_six_r7: assert property (@(posedge clk) disable iff (!rst_n)
      state == 3'd6 |=> state == 3'd3);
endmodule

bind jkseq_counter jkseq_counter_chk #(.RESET_CODE(RESET_CODE)) u_chk (
   .clk(clk), .rst_n(rst_n), .state(state));

// File: tb/test_jkseq_counter.sv
`timescale 1ns/1ps
module test_jkseq_counter;
   logic clk = 1'b0;
   logic rst_n;
   logic [2:0] st_jk, st_eq;
   logic [2:0] st_un [2][3];
   int vectors = 0;
   int fails = 0;
   bit done = 0;

   localparam logic [2:0] UNUSED_CODES [3] = '{3'd1, 3'd5, 3'd6};

   always #2 clk = ~clk;

   jkseq_counter i_jkseq_counter (.clk(clk), .rst_n(rst_n), .state(st_jk));
   jkseq_counter #(.USE_JK_FORM(0)) i_eq (.clk(clk), .rst_n(rst_n), .state(st_eq));

   for (genvar f = 0; f < 2; f++) begin : g_form
      for (genvar c = 0; c < 3; c++) begin : g_code
         jkseq_counter #(.USE_JK_FORM(1 - f), .RESET_CODE(UNUSED_CODES[c])) i_un (
            .clk(clk), .rst_n(rst_n), .state(st_un[f][c]));
      end
   end

   function automatic logic [2:0] succ(input logic [2:0] c);
      case (c)
         3'd4: succ = 3'd7;  3'd7: succ = 3'd3;  3'd3: succ = 3'd0;
         3'd0: succ = 3'd2;  3'd2: succ = 3'd4;  3'd1: succ = 3'd2;
         3'd5: succ = 3'd7;  default: succ = 3'd3;
      endcase
   endfunction

   function automatic bit looped(input logic [2:0] c);
      looped = (c == 3'd4) || (c == 3'd7) || (c == 3'd3) || (c == 3'd0) || (c == 3'd2);
   endfunction

   task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic string exit_req(input int c);
      exit_req = (c == 0) ? "R5" : (c == 1) ? "R6" : "R7";
   endfunction

   task automatic t_reset();
      repeat (2) @(negedge clk);
      chk("R1 reset jk", st_jk, 3'd4);
      chk("R1 reset eq", st_eq, 3'd4);
      for (int f = 0; f < 2; f++)
         for (int c = 0; c < 3; c++)
            chk("R1 reset unused", st_un[f][c], UNUSED_CODES[c]);
      rst_n = 1'b1;
   endtask

   task automatic t_first_edge();
      @(negedge clk);
      chk("R1 R2 first step", st_jk, 3'd7);
      chk("R8 first step eq", st_eq, 3'd7);
      for (int f = 0; f < 2; f++)
         for (int c = 0; c < 3; c++)
            chk(exit_req(c), st_un[f][c], succ(UNUSED_CODES[c]));
   endtask

   task automatic t_cycle();
      logic [2:0] exp = 3'd7;
      logic [2:0] hist [16];
      logic [2:0] uexp [2][3];
      for (int f = 0; f < 2; f++)
         for (int c = 0; c < 3; c++) uexp[f][c] = succ(UNUSED_CODES[c]);
      hist[0] = exp;
      for (int s = 1; s <= 10; s++) begin
         exp = succ(exp);
         @(negedge clk);
         hist[s] = st_jk;
         chk("R2 loop step", st_jk, exp);
         chk("R8 forms agree", st_eq, st_jk);
         if (s >= 5) chk("R3 period five", st_jk, hist[s-5]);
         for (int f = 0; f < 2; f++)
            for (int c = 0; c < 3; c++) begin
               uexp[f][c] = succ(uexp[f][c]);
               chk("R4 stays in loop", st_un[f][c], uexp[f][c]);
               chk("R4 loop member", {2'b00, looped(st_un[f][c])}, 3'd1);
            end
      end
   endtask

   task automatic t_async_reset();
      @(negedge clk);
      #0.5 rst_n = 1'b0;
      #1;
      chk("R9 async jk", st_jk, 3'd4);
      chk("R9 async eq", st_eq, 3'd4);
      for (int f = 0; f < 2; f++)
         for (int c = 0; c < 3; c++)
            chk("R9 async unused", st_un[f][c], UNUSED_CODES[c]);
      @(negedge clk);
      chk("R1 hold in reset", st_jk, 3'd4);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 restart", st_jk, 3'd7);
      chk("R8 restart eq", st_eq, 3'd7);
   endtask

   initial begin
      rst_n = 1'b1;
      #1 rst_n = 1'b0;
      t_reset();
      t_first_edge();
      t_cycle();
      t_async_reset();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         vectors++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule